// File: doc/BRIEF.md
# Serial Flash Status Register Write-Protect Slave

This block is the command-side slave logic that guards the 8-bit status register of a serial flash. It watches the serial clock, the active-low chip select, the serial data input and the active-low write-protect pin, all of which it brings into its own clock domain through a synchronizer chain. It decodes three instructions. Two arm the register for a write: one of them also sets a visible write-enable latch and the other does not. The third carries a new status byte. That byte is applied only when chip select returns high, and only when the frame held exactly sixteen serial clocks.

Whether a write is applied depends on the write-protect pin and on a lock bit held in the register. While the pin is high, every writable field can change, and this includes clearing the lock. While the pin is low, the lock can be set but never cleared, and once it is set the register is frozen. The register is presented on a parallel output for observation. Serial clock modes 0 and 3 both work, because data is taken only on rising serial clock edges while chip select is low.

Top module: `sreg_wp_slave`

## Requirements
- R1: After reset, statusOut equals RESET_STATUS masked to the writable field (bits 7 and 5:2). Bit 1 (write-enable latch), bit 6 and bit 0 (busy) read 0.
- R2: A write-status frame is opcode 0x01 followed by one data byte, both MSB first. When armed and allowed, it copies data bits 7 and 5:2 into statusOut, and only once chip select goes high.
- R3: A write-status frame does nothing unless an enable instruction completed beforehand in its own chip-select period.
- R4: Opcode 0x06 (exactly 8 clocks) sets statusOut bit 1. Opcode 0x50 (exactly 8 clocks) arms a write without changing statusOut.
- R5: While the write-protect pin is low and bit 7 (lock) is 1, a write-status frame leaves bits 7:2 unchanged.
- R6: While the write-protect pin is low and the lock is 0, one write-status frame can set the lock and change bits 5:2 at the same time. The lock never goes from 1 to 0 while the pin is low.
- R7: While the write-protect pin is high, a write-status frame can change every writable bit, and this includes clearing the lock.
- R8: Data bits 6, 1 and 0 of a write-status frame never reach statusOut. Bit 6 and bit 0 stay 0.
- R9: A write-status frame whose chip-select period holds any number of rising serial clocks other than 16 is discarded. The register stays unchanged and the armed state is kept.
- R10: Every write-status frame of exactly 16 clocks clears the write-enable latch and the armed state, whether or not the data was applied.
- R11: Unknown opcodes have no effect, and the bit count restarts at every falling edge of chip select.
- R12: Serial clock mode 0 (idle low) and mode 3 (idle high) give identical results.
- R13: A register change appears after the SYNC_STAGES-th rising clock edge that follows the first edge at which chip select is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, which oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sckPin | input | 1 | Serial clock from the host |
| csNPin | input | 1 | Active-low chip select |
| siPin | input | 1 | Serial data in, MSB first |
| wpNPin | input | 1 | Active-low write-protect pin |
| statusOut | output | 8 | Status register: lock at bit 7, protect field at 5:2, write-enable latch at bit 1, busy at bit 0 |

## Verification
The bench builds the block with SYNC_STAGES set to 3 and RESET_STATUS set to 8'h3C. The deeper synchronizer makes the model's delay line exercise a latency other than the default. The reset value starts all four protect bits set, so clearing them under both pin states can be seen. With these values, the lock-set and lock-frozen cases, the 15-bit and 17-bit aborted frames and the mode-3 frames are all reached within a few thousand cycles.

// File: rtl/sreg_wp_pkg.sv
package sreg_wp_pkg;

  localparam int STATUS_W = 8;
  localparam int LOCK_BIT = 7;
  localparam int WEL_BIT  = 1;
  localparam logic [STATUS_W-1:0] WRITABLE_MASK = 8'hBC;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic clrFrame;
    logic shiftEn;
    logic latchOp;
    logic setWel;
    logic setArm;
    logic commitWrite;
  } ctrlStrobes_t;

endpackage

// File: rtl/sreg_wp_sync.sv
module sreg_wp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RESET_VAL;
    else       chain[0] <= pinIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RESET_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sreg_wp_ctrl.sv
module sreg_wp_ctrl
  import sreg_wp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OP_WREN = 'h06,
  parameter logic [BYTE_W-1:0] OP_EWSR = 'h50,
  parameter logic [BYTE_W-1:0] OP_WRSR = 'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckLvl,
  input  logic              csNLvl,
  input  logic [BYTE_W-1:0] opcode,
  output ctrlStrobes_t      strobes
);

  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int SAT_COUNT  = FRAME_BITS + 1;
  localparam int CNT_W      = $clog2(SAT_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SAT_COUNT);

  logic             sckPrev, csNPrev;
  logic             sckRise, csFall, csRise;
  logic [CNT_W-1:0] bitCnt;
  logic             opDone, frameDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csNPrev <= 1'b1;
    end else begin
      sckPrev <= sckLvl;
      csNPrev <= csNLvl;
    end
  end

  assign sckRise = sckLvl & ~sckPrev;
  assign csFall  = ~csNLvl & csNPrev;
  assign csRise  = csNLvl & ~csNPrev;

  assign opDone    = (bitCnt == CNT_OP);
  assign frameDone = (bitCnt == CNT_FULL);

  always_comb begin
    strobes = '0;
    if (csFall) begin
      strobes.clrFrame = 1'b1;
    end else if (!csNLvl && sckRise) begin
      strobes.shiftEn = 1'b1;
      strobes.latchOp = (bitCnt == CNT_LAST);
    end
    if (csRise) begin
      strobes.setWel      = opDone && (opcode == OP_WREN);
      strobes.setArm      = opDone && (opcode == OP_EWSR);
      strobes.commitWrite = frameDone && (opcode == OP_WRSR);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                bitCnt <= '0;
    else if (strobes.clrFrame)                bitCnt <= '0;
    else if (strobes.shiftEn && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

endmodule

// File: rtl/sreg_wp_datapath.sv
module sreg_wp_datapath
  import sreg_wp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [STATUS_W-1:0] RESET_STATUS = 8'h3C
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                siLvl,
  input  logic                wpNLvl,
  output logic [BYTE_W-1:0]   opcode,
  output logic [STATUS_W-1:0] statusOut
);

  logic [BYTE_W-1:0]   shiftReg, shiftNext;
  logic [STATUS_W-1:0] protReg, newProt;
  logic                wel, arm;
  logic                writeAllowed;

  assign shiftNext = {shiftReg[BYTE_W-2:0], siLvl};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      opcode   <= '0;
    end else begin
      if (strobes.clrFrame)     shiftReg <= '0;
      else if (strobes.shiftEn) shiftReg <= shiftNext;
      if (strobes.latchOp)      opcode   <= shiftNext;
    end
  end

  assign writeAllowed = (wel || arm) && !(!wpNLvl && protReg[LOCK_BIT]);
  assign newProt      = STATUS_W'(shiftReg) & WRITABLE_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protReg <= RESET_STATUS & WRITABLE_MASK;
      wel     <= 1'b0;
      arm     <= 1'b0;
    end else begin
      if (strobes.commitWrite) begin
        if (writeAllowed) protReg <= newProt;
        wel <= 1'b0;
        arm <= 1'b0;
      end
      if (strobes.setWel) wel <= 1'b1;
      if (strobes.setArm) arm <= 1'b1;
    end
  end

  always_comb begin
    statusOut          = protReg & WRITABLE_MASK;
    statusOut[WEL_BIT] = wel;
  end

endmodule

// File: rtl/sreg_wp_slave.sv
module sreg_wp_slave
  import sreg_wp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W = 8,
  parameter logic [STATUS_W-1:0] RESET_STATUS = 8'h3C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sckPin,
  input  logic                csNPin,
  input  logic                siPin,
  input  logic                wpNPin,
  output logic [STATUS_W-1:0] statusOut
);

  // pin order {wpN, si, csN, sck}; idle reset values
  localparam logic [3:0] PIN_IDLE = 4'b1010;

  logic [3:0]        pinsSync;
  logic              sckLvl, csNLvl, siLvl, wpNLvl;
  logic [BYTE_W-1:0] opcode;
  ctrlStrobes_t      strobes;

  sreg_wp_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RESET_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinIn({wpNPin, siPin, csNPin, sckPin}),
    .syncOut(pinsSync)
  );

  assign {wpNLvl, siLvl, csNLvl, sckLvl} = pinsSync;

  sreg_wp_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckLvl(sckLvl), .csNLvl(csNLvl),
    .opcode(opcode), .strobes(strobes)
  );

  sreg_wp_datapath #(.BYTE_W(BYTE_W), .RESET_STATUS(RESET_STATUS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .siLvl(siLvl),
    .wpNLvl(wpNLvl), .opcode(opcode), .statusOut(statusOut)
  );

endmodule

// File: rtl/sreg_wp_checker.sv
module sreg_wp_checker
  import sreg_wp_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [STATUS_W-1:0] statusOut,
  input logic                wpNLvl,
  input ctrlStrobes_t        strobes
);

  AST_CHANGE_ONLY_ON_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut != $past(statusOut)) |-> $past(strobes.setWel || strobes.commitWrite)); // R2

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusOut[7]) && !$past(wpNLvl)) |-> (statusOut[7:2] == $past(statusOut[7:2]))); // R5

  AST_LOCK_NEVER_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusOut[7]) && !$past(wpNLvl)) |-> statusOut[7]); // R6

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.setWel) |-> statusOut[1]); // R4

  AST_WEL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.commitWrite) |-> !statusOut[1]); // R10

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.setWel, strobes.setArm, strobes.commitWrite})); // R11

endmodule

bind sreg_wp_slave sreg_wp_checker u_chk (
  .clk(clk), .rstN(rstN), .statusOut(statusOut), .wpNLvl(wpNLvl), .strobes(strobes)
);

// File: tb/sreg_wp_slave_tb.sv
`timescale 1ns/1ps
module sreg_wp_slave_tb;

  localparam int SYNC = 3;
  localparam logic [7:0] RST_VAL = 8'h3C;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckPin = 1'b0, csNPin = 1'b1, siPin = 1'b0, wpNPin = 1'b1;
  logic [7:0] statusOut;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  sreg_wp_slave #(.SYNC_STAGES(SYNC), .RESET_STATUS(RST_VAL)) u_dut (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .csNPin(csNPin),
    .siPin(siPin), .wpNPin(wpNPin), .statusOut(statusOut)
  );

  // behavioural reference model
  logic [7:0] mProt;
  bit mWel, mArm, mPrevCs, mPrevSck;
  int mCnt;
  logic [7:0] mSh, mOp;
  logic [7:0] hist[$];

  function automatic logic [7:0] modelStatus();
    return (mProt & 8'hBC) | {6'b0, mWel, 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mProt = RST_VAL & 8'hBC; mWel = 0; mArm = 0;
      mPrevCs = 1; mPrevSck = 0; mCnt = 0; mSh = 0; mOp = 0;
      hist.delete();
      for (int i = 0; i <= SYNC; i++) hist.push_back(modelStatus());
    end else begin
      if (mPrevCs && !csNPin) begin
        mCnt = 0; mSh = 0;
      end else if (!csNPin && !mPrevSck && sckPin) begin
        mSh = {mSh[6:0], siPin};
        mCnt++;
        if (mCnt == 8) mOp = mSh;
      end
      if (!mPrevCs && csNPin) begin
        if (mCnt == 8 && mOp == 8'h06) mWel = 1;
        if (mCnt == 8 && mOp == 8'h50) mArm = 1;
        if (mCnt == 16 && mOp == 8'h01) begin
          if ((mWel || mArm) && !(!wpNPin && mProt[7])) mProt = mSh & 8'hBC;
          mWel = 0; mArm = 0;
        end
      end
      mPrevCs = csNPin; mPrevSck = sckPin;
      hist.push_back(modelStatus());
      if (hist.size() > SYNC + 1) void'(hist.pop_front());
    end
  end

  // cycle-by-cycle comparison, latency per R13
  always @(negedge clk) begin
    if (rstN && !done && hist.size() == SYNC + 1) begin
      checks++;
      if (statusOut !== hist[0]) begin
        fails++;
        $display("FAIL %s/R13 cycle compare: actual %02h expected %02h", curReq, statusOut, hist[0]);
      end
    end
  end

  task automatic checkStatus(input logic [7:0] exp, input string req);
    checks++;
    if (statusOut !== exp) begin
      fails++;
      $display("FAIL %s status: actual %02h expected %02h", req, statusOut, exp);
    end
  endtask

  task automatic spiXfer(input logic [31:0] bits, input int n, input bit mode3);
    sckPin = mode3;
    repeat (HALF) @(negedge clk);
    csNPin = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sckPin = 1'b0; siPin = bits[i];
      repeat (HALF) @(negedge clk);
      sckPin = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    if (!mode3) begin
      sckPin = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    csNPin = 1'b1;
    repeat (SYNC + 4) @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    curReq = "R1"; checkStatus(8'h3C, "R1");
    rstN = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    checkStatus(8'h3C, "R1");

    curReq = "R3"; spiXfer(32'h0100, 16, 0); checkStatus(8'h3C, "R3");
    curReq = "R4"; spiXfer(32'h06, 8, 0); checkStatus(8'h3E, "R4");
    curReq = "R2"; spiXfer(32'h0184, 16, 0); checkStatus(8'h84, "R2");

    curReq = "R12"; spiXfer(32'h50, 8, 1); checkStatus(8'h84, "R4 R12");
    curReq = "R7"; spiXfer(32'h0100, 16, 1); checkStatus(8'h00, "R7 R12");

    wpNPin = 1'b0;
    curReq = "R6"; spiXfer(32'h06, 8, 0); checkStatus(8'h02, "R6");
    spiXfer(32'h01A8, 16, 0); checkStatus(8'hA8, "R6");
    curReq = "R5"; spiXfer(32'h06, 8, 0); checkStatus(8'hAA, "R5");
    spiXfer(32'h0100, 16, 0); checkStatus(8'hA8, "R5 R10");
    spiXfer(32'h50, 8, 1); spiXfer(32'h0100, 16, 1); checkStatus(8'hA8, "R5");

    wpNPin = 1'b1;
    curReq = "R8"; spiXfer(32'h06, 8, 0); checkStatus(8'hAA, "R8");
    spiXfer(32'h01FF, 16, 0); checkStatus(8'hBC, "R8");

    curReq = "R9"; spiXfer(32'h06, 8, 0); checkStatus(8'hBE, "R9");
    spiXfer(32'h0080, 15, 0); checkStatus(8'hBE, "R9");
    spiXfer(32'h0200, 17, 0); checkStatus(8'hBE, "R9");
    spiXfer(32'h0100, 16, 0); checkStatus(8'h00, "R9 R10");

    curReq = "R11"; spiXfer(32'hAB, 8, 0); checkStatus(8'h00, "R11");
    spiXfer(32'h00C, 9, 0); checkStatus(8'h00, "R11");
    spiXfer(32'h0, 3, 0); spiXfer(32'h06, 8, 0); checkStatus(8'h02, "R11");
    spiXfer(32'h0110, 16, 1); checkStatus(8'h10, "R11 R12");

    repeat (10) @(negedge clk);
    summary();
  end

endmodule